// File: doc/BRIEF.md
# UDP Transmit Header Framer

The framer sits between a UDP user and an IP transmit layer and carries one datagram at a time. A one-cycle request pulse hands over the destination IP address, both ports, the payload length and the checksum. The block captures them, raises a one-cycle start towards the IP layer with a descriptor (destination address, protocol 17, IP payload length equal to UDP payload length plus 8), and then drives the 8-byte UDP header followed by the caller's payload stream on a byte-wide valid/last interface. The IP layer's ready input paces every byte.

A 2-bit status reports progress: none, sending, sent or error. The same encoding is used on the status input from the IP layer. The block's status follows that input once the datagram is under way. It then holds until the next request.

The controller has five states. ST_IDLE waits for a request; a request there moves to ST_ANNOUNCE. ST_ANNOUNCE lasts one cycle and always moves to ST_HEADER. ST_HEADER moves through the header bytes, one per ready cycle. After the last header byte it goes to ST_BODY, or to ST_AWAIT if the declared length is zero. ST_BODY relays payload and moves to ST_AWAIT when the byte marked last is accepted. ST_AWAIT returns to ST_IDLE when the IP layer reports sent or error.

Top module: `udp_tx_framer`

## Requirements
- R1: After reset, ip_start_o, ip_valid_o, ip_last_o and pl_ready_o are low and tx_status_o is 0 (none), even with ip_ready_i high.
- R2: A req_start_i pulse in the idle state makes tx_status_o read 1 (sending) and ip_start_o high on the next cycle. ip_start_o stays high for exactly one cycle. ip_dst_ip_o shows the captured address, ip_proto_o reads 17, and ip_len_o reads the payload length plus 8 modulo 2^16.
- R3: Header bytes leave on ip_data_o with ip_valid_o high, big-endian, in this order: source port, destination port, length plus 8 (modulo 2^16), checksum.
- R4: While ip_ready_i is low during the header, the offered header byte and ip_valid_o are held unchanged.
- R5: During the payload, pl_ready_o equals ip_ready_i. ip_data_o and ip_valid_o follow pl_data_i and pl_valid_i, and bytes leave in arrival order. pl_ready_o is never high while ip_ready_i is low.
- R6: ip_last_o is high on the byte that carries pl_last_i, and on no other byte of the datagram.
- R7: With a declared length of zero, ip_last_o is high on the final checksum byte, no payload phase follows, and pl_ready_o stays low.
- R8: After the payload, an IP status of 2 (sent) or 3 (error) sets tx_status_o to the same code on the next cycle and frees the block for a new request.
- R9: A req_start_i pulse while a datagram is in progress is ignored. No ip_start_o appears, the descriptor stays unchanged, and the byte stream is not disturbed.
- R10: Once set to sent or error, tx_status_o keeps its value after the IP status returns to 0, until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_start_i | input | 1 | One-cycle request to send a datagram |
| req_dst_ip_i | input | 32 | Destination IP address |
| req_dst_port_i | input | 16 | Destination port |
| req_src_port_i | input | 16 | Source port |
| req_len_i | input | 16 | Payload length in bytes |
| req_csum_i | input | 16 | UDP checksum |
| pl_data_i | input | 8 | Payload byte |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_last_i | input | 1 | Payload byte is the final one |
| pl_ready_o | output | 1 | Framer accepts a payload byte this cycle |
| tx_status_o | output | 2 | 0 none, 1 sending, 2 sent, 3 error |
| ip_start_o | output | 1 | One-cycle start towards the IP layer |
| ip_dst_ip_o | output | 32 | Descriptor: destination address |
| ip_proto_o | output | 8 | Descriptor: protocol number (17) |
| ip_len_o | output | 16 | Descriptor: IP payload length |
| ip_status_i | input | 2 | IP layer status, same encoding as tx_status_o |
| ip_ready_i | input | 1 | IP layer accepts a byte this cycle |
| ip_data_o | output | 8 | Byte to the IP layer |
| ip_valid_o | output | 1 | ip_data_o valid |
| ip_last_o | output | 1 | ip_data_o is the datagram's last byte |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit ports and lengths, and byte-wide data. The header is therefore exactly 8 bytes. With 16-bit lengths, a declared length near the top of the range makes the added 8 wrap, and the bench checks that wrap in both the descriptor and the header. Lengths up to a few dozen bytes, random ready duty cycles and gaps in payload valid exercise stalls in both phases. A zero length exercises the skipped payload phase.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ANNOUNCE,
        ST_HEADER,
        ST_BODY,
        ST_AWAIT
    } fr_state_e;

    localparam logic [1:0] TXS_NONE    = 2'd0;
    localparam logic [1:0] TXS_SENDING = 2'd1;
    localparam logic [1:0] TXS_SENT    = 2'd2;
    localparam logic [1:0] TXS_ERROR   = 2'd3;

    localparam logic [7:0] PROTO_UDP = 8'd17;

endpackage

// File: rtl/udp_hdr_mux.sv
module udp_hdr_mux #(
    parameter int PORT_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = 4 * PORT_W / BYTE_W,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic [PORT_W-1:0] src_port_i,
    input  logic [PORT_W-1:0] dst_port_i,
    input  logic [PORT_W-1:0] total_len_i,
    input  logic [PORT_W-1:0] csum_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [4*PORT_W-1:0] hdr_vec;
    logic [BYTE_W-1:0]   bytes [NB];

    assign hdr_vec = {src_port_i, dst_port_i, total_len_i, csum_i};

    // Byte 0 is the most significant byte of the first field (network order)
    for (genvar b = 0; b < NB; b++) begin : g_split
        assign bytes[b] = hdr_vec[(NB-1-b)*BYTE_W +: BYTE_W];
    end

    assign byte_o = bytes[idx_i];

endmodule

// File: rtl/udp_tx_fsm.sv
module udp_tx_fsm
    import udp_tx_pkg::*;
#(
    parameter int NB     = 8,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             len_zero_i,
    input  logic             ip_ready_i,
    input  logic             pl_valid_i,
    input  logic             pl_last_i,
    input  logic [1:0]       ip_status_i,
    output logic             accept_o,
    output logic             announce_o,
    output logic             header_o,
    output logic             body_o,
    output logic             hdr_last_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NB - 1);

    fr_state_e        st_q, st_nx;
    logic [IDX_W-1:0] idx_q, idx_nx;
    logic             done_report;

    assign done_report = (ip_status_i == TXS_SENT) || (ip_status_i == TXS_ERROR);

    always_comb begin
        st_nx  = st_q;
        idx_nx = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_nx  = ST_ANNOUNCE;
                    idx_nx = '0;
                end
            end
            ST_ANNOUNCE: st_nx = ST_HEADER;
            ST_HEADER: begin
                if (ip_ready_i) begin
                    if (idx_q == IDX_LAST) begin
                        st_nx = len_zero_i ? ST_AWAIT : ST_BODY;
                    end else begin
                        idx_nx = idx_q + 1'b1;
                    end
                end
            end
            ST_BODY: begin
                if (ip_ready_i && pl_valid_i && pl_last_i) st_nx = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (done_report) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_nx;
            idx_q <= idx_nx;
        end
    end

    // Output decode process
    always_comb begin
        accept_o   = 1'b0;
        announce_o = 1'b0;
        header_o   = 1'b0;
        body_o     = 1'b0;
        hdr_last_o = 1'b0;
        busy_o     = 1'b0;
        unique case (st_q)
            ST_IDLE:     accept_o = start_i;
            ST_ANNOUNCE: announce_o = 1'b1;
            ST_HEADER: begin
                header_o   = 1'b1;
                busy_o     = 1'b1;
                hdr_last_o = len_zero_i && (idx_q == IDX_LAST);
            end
            ST_BODY: begin
                body_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_AWAIT: busy_o = 1'b1;
            default: ;
        endcase
    end

    assign idx_o = idx_q;

    // R4: a stalled header byte keeps its position
    a_r4_hold_idx: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HEADER && !ip_ready_i) |=> (st_q == ST_HEADER && $stable(idx_q)));

    // R8: a completion report in the await state frees the block
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AWAIT && done_report) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/udp_tx_status.sv
module udp_tx_status
    import udp_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept_i,
    input  logic       track_i,
    input  logic [1:0] ip_status_i,
    output logic [1:0] status_o
);

    logic [1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= TXS_NONE;
        end else if (accept_i) begin
            status_q <= TXS_SENDING;
        end else if (track_i && ip_status_i == TXS_SENT) begin
            status_q <= TXS_SENT;
        end else if (track_i && ip_status_i == TXS_ERROR) begin
            status_q <= TXS_ERROR;
        end
    end

    assign status_o = status_q;

    // R2: an accepted request reads as sending on the next cycle
    a_r2_sending: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> (status_o == TXS_SENDING));

    // R8: a sent report is reflected on the next cycle
    a_r8_sent: assert property (@(posedge clk) disable iff (rst)
        (track_i && !accept_i && ip_status_i == TXS_SENT) |=> (status_o == TXS_SENT));

    // R10: without a request or an active datagram the status is held
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!accept_i && !track_i) |=> $stable(status_o));

endmodule

// File: rtl/udp_tx_framer.sv
module udp_tx_framer
    import udp_tx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter int BYTE_W = 8,
    localparam int HDR_BYTES = 4 * PORT_W / BYTE_W,
    localparam int IDX_W     = $clog2(HDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start_i,
    input  logic [ADDR_W-1:0] req_dst_ip_i,
    input  logic [PORT_W-1:0] req_dst_port_i,
    input  logic [PORT_W-1:0] req_src_port_i,
    input  logic [PORT_W-1:0] req_len_i,
    input  logic [PORT_W-1:0] req_csum_i,
    input  logic [BYTE_W-1:0] pl_data_i,
    input  logic              pl_valid_i,
    input  logic              pl_last_i,
    output logic              pl_ready_o,
    output logic [1:0]        tx_status_o,
    output logic              ip_start_o,
    output logic [ADDR_W-1:0] ip_dst_ip_o,
    output logic [7:0]        ip_proto_o,
    output logic [PORT_W-1:0] ip_len_o,
    input  logic [1:0]        ip_status_i,
    input  logic              ip_ready_i,
    output logic [BYTE_W-1:0] ip_data_o,
    output logic              ip_valid_o,
    output logic              ip_last_o
);

    logic [ADDR_W-1:0] dst_ip_q;
    logic [PORT_W-1:0] dst_port_q, src_port_q, total_len_q, csum_q;
    logic              len_zero_q;

    logic             accept, announce, header, body, hdr_last, busy;
    logic [IDX_W-1:0] idx;
    logic [BYTE_W-1:0] hdr_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_ip_q    <= '0;
            dst_port_q  <= '0;
            src_port_q  <= '0;
            total_len_q <= '0;
            csum_q      <= '0;
            len_zero_q  <= 1'b0;
        end else if (accept) begin
            dst_ip_q    <= req_dst_ip_i;
            dst_port_q  <= req_dst_port_i;
            src_port_q  <= req_src_port_i;
            total_len_q <= req_len_i + PORT_W'(HDR_BYTES);
            csum_q      <= req_csum_i;
            len_zero_q  <= (req_len_i == '0);
        end
    end

    udp_tx_fsm #(.NB(HDR_BYTES)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (req_start_i),
        .len_zero_i (len_zero_q),
        .ip_ready_i (ip_ready_i),
        .pl_valid_i (pl_valid_i),
        .pl_last_i  (pl_last_i),
        .ip_status_i(ip_status_i),
        .accept_o   (accept),
        .announce_o (announce),
        .header_o   (header),
        .body_o     (body),
        .hdr_last_o (hdr_last),
        .busy_o     (busy),
        .idx_o      (idx)
    );

    udp_hdr_mux #(.PORT_W(PORT_W), .BYTE_W(BYTE_W)) mux_i (
        .src_port_i (src_port_q),
        .dst_port_i (dst_port_q),
        .total_len_i(total_len_q),
        .csum_i     (csum_q),
        .idx_i      (idx),
        .byte_o     (hdr_byte)
    );

    udp_tx_status status_i (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .track_i    (busy),
        .ip_status_i(ip_status_i),
        .status_o   (tx_status_o)
    );

    assign ip_start_o  = announce;
    assign ip_dst_ip_o = dst_ip_q;
    assign ip_proto_o  = PROTO_UDP;
    assign ip_len_o    = total_len_q;

    assign pl_ready_o = body && ip_ready_i;
    assign ip_valid_o = header || (body && pl_valid_i);
    assign ip_data_o  = header ? hdr_byte : (body ? pl_data_i : '0);
    assign ip_last_o  = hdr_last || (body && pl_valid_i && pl_last_i);

    // R2: the start towards the IP layer is a single-cycle pulse
    a_r2_one_pulse: assert property (@(posedge clk) disable iff (rst)
        ip_start_o |=> !ip_start_o);

    // R6: a last marker only accompanies a valid byte
    a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
        ip_last_o |-> ip_valid_o);

    // R9: the descriptor changes only when a request is accepted
    a_r9_desc_stable: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(ip_dst_ip_o) && $stable(ip_len_o)));

    // R4: a stalled header byte is still offered on the next cycle
    a_r4_hold_byte: assert property (@(posedge clk) disable iff (rst)
        (header && !ip_ready_i) |=> (ip_valid_o && $stable(ip_data_o)));

endmodule

// File: tb/udp_tx_framer_tb_top.sv
module udp_tx_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_start_i = 1'b0;
    logic [31:0] req_dst_ip_i = '0;
    logic [15:0] req_dst_port_i = '0, req_src_port_i = '0, req_len_i = '0, req_csum_i = '0;
    logic [7:0]  pl_data_i = '0;
    logic        pl_valid_i = 1'b0, pl_last_i = 1'b0;
    logic        pl_ready_o;
    logic [1:0]  tx_status_o;
    logic        ip_start_o;
    logic [31:0] ip_dst_ip_o;
    logic [7:0]  ip_proto_o;
    logic [15:0] ip_len_o;
    logic [1:0]  ip_status_i = '0;
    logic        ip_ready_i = 1'b0;
    logic [7:0]  ip_data_o;
    logic        ip_valid_o, ip_last_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] pay [0:63];

    always #4 clk = ~clk;

    udp_tx_framer dut_i (
        .clk(clk), .rst(rst), .req_start_i(req_start_i),
        .req_dst_ip_i(req_dst_ip_i), .req_dst_port_i(req_dst_port_i),
        .req_src_port_i(req_src_port_i), .req_len_i(req_len_i), .req_csum_i(req_csum_i),
        .pl_data_i(pl_data_i), .pl_valid_i(pl_valid_i), .pl_last_i(pl_last_i),
        .pl_ready_o(pl_ready_o), .tx_status_o(tx_status_o), .ip_start_o(ip_start_o),
        .ip_dst_ip_o(ip_dst_ip_o), .ip_proto_o(ip_proto_o), .ip_len_o(ip_len_o),
        .ip_status_i(ip_status_i), .ip_ready_i(ip_ready_i), .ip_data_o(ip_data_o),
        .ip_valid_o(ip_valid_o), .ip_last_o(ip_last_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hdr(input logic [15:0] sp, input logic [15:0] dp,
                                           input logic [15:0] ln, input logic [15:0] cs, input int k);
        logic [63:0] v;
        v = {sp, dp, 16'(ln + 16'd8), cs};
        return v[(7-k)*8 +: 8];
    endfunction

    task automatic scramble_req();
        req_dst_ip_i   = $urandom;
        req_dst_port_i = 16'($urandom);
        req_src_port_i = 16'($urandom);
        req_len_i      = 16'($urandom);
        req_csum_i     = 16'($urandom);
    endtask

    task automatic send_pkt(input logic [31:0] dip, input logic [15:0] sp, input logic [15:0] dp,
                            input logic [15:0] ln, input logic [15:0] cs, input int npay,
                            input int rdy_pct, input bit intrude, input bit use_err);
        int total, got, pi, guard;
        bit saw_start, bad_gate, saw_plr, prev_stall;
        logic [7:0] prev_byte, expb;
        logic [1:0] exp_st;
        for (int i = 0; i < npay; i++) pay[i] = 8'($urandom);
        total = 8 + npay; got = 0; pi = 0; guard = 0;
        saw_start = 0; bad_gate = 0; saw_plr = 0; prev_stall = 0; prev_byte = '0;
        @(negedge clk);
        req_dst_ip_i = dip; req_src_port_i = sp; req_dst_port_i = dp;
        req_len_i = ln; req_csum_i = cs; req_start_i = 1'b1;
        @(negedge clk);
        req_start_i = 1'b0;
        scramble_req();
        #1;
        check(tx_status_o == 2'd1, "R2 status sending", 64'(tx_status_o), 64'd1);
        check(ip_start_o == 1'b1, "R2 ip start", 64'(ip_start_o), 64'd1);
        check(ip_dst_ip_o == dip, "R2 dst ip", 64'(ip_dst_ip_o), 64'(dip));
        check(ip_len_o == 16'(ln + 16'd8), "R2 ip length", 64'(ip_len_o), 64'(16'(ln + 16'd8)));
        check(ip_proto_o == 8'd17, "R2 protocol", 64'(ip_proto_o), 64'd17);
        while (got < total && guard < 4000) begin
            @(negedge clk);
            guard++;
            ip_ready_i  = ($urandom % 100) < rdy_pct;
            pl_valid_i  = (pi < npay) ? (($urandom % 4) != 0) : 1'b0;
            pl_data_i   = (pi < npay) ? pay[pi] : 8'h00;
            pl_last_i   = (pi == npay - 1);
            if (intrude && got == 4) begin
                scramble_req();
                req_start_i = 1'b1;
            end else begin
                req_start_i = 1'b0;
            end
            #1;
            if (ip_start_o) saw_start = 1;
            if (pl_ready_o && !ip_ready_i) bad_gate = 1;
            if (pl_ready_o) saw_plr = 1;
            if (prev_stall) begin
                // R4: stalled header byte must be offered again unchanged
                check(ip_valid_o && ip_data_o == prev_byte, "R4 header hold",
                      64'(ip_data_o), 64'(prev_byte));
            end
            prev_stall = (got < 8) && ip_valid_o && !ip_ready_i;
            prev_byte  = ip_data_o;
            if (pl_valid_i && pl_ready_o) pi++;
            if (ip_valid_o && ip_ready_i) begin
                expb = (got < 8) ? exp_hdr(sp, dp, ln, cs, got) : pay[got-8];
                check(ip_data_o == expb, (got < 8) ? "R3 header byte" : "R5 payload byte",
                      64'(ip_data_o), 64'(expb));
                if (got == total - 1 || ip_last_o)
                    check(ip_last_o == (got == total - 1), (npay == 0) ? "R7 last on checksum" : "R6 last flag",
                          64'(ip_last_o), 64'(got == total - 1));
                got++;
            end
        end
        @(negedge clk);
        ip_ready_i = 1'b0; pl_valid_i = 1'b0; pl_last_i = 1'b0; req_start_i = 1'b0;
        #1;
        check(got == total, "R5 stream complete", 64'(got), 64'(total));
        check(!saw_start, "R9 no restart", 64'(saw_start), 64'd0);
        check(ip_dst_ip_o == dip, "R9 descriptor kept", 64'(ip_dst_ip_o), 64'(dip));
        check(!bad_gate, "R5 ready gating", 64'(bad_gate), 64'd0);
        if (npay == 0) check(!saw_plr, "R7 no payload phase", 64'(saw_plr), 64'd0);
        check(tx_status_o == 2'd1, "R8 still sending", 64'(tx_status_o), 64'd1);
        exp_st = use_err ? 2'd3 : 2'd2;
        ip_status_i = exp_st;
        @(negedge clk);
        #1;
        check(tx_status_o == exp_st, "R8 status follows", 64'(tx_status_o), 64'(exp_st));
        ip_status_i = 2'd0;
        repeat (2) @(negedge clk);
        #1;
        check(tx_status_o == exp_st, "R10 status held", 64'(tx_status_o), 64'(exp_st));
        check(!ip_valid_o, "R8 idle after report", 64'(ip_valid_o), 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2011);
        rst = 1'b1;
        ip_ready_i = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(!ip_start_o, "R1 ip start low", 64'(ip_start_o), 64'd0);
        check(!ip_valid_o, "R1 ip valid low", 64'(ip_valid_o), 64'd0);
        check(!ip_last_o, "R1 ip last low", 64'(ip_last_o), 64'd0);
        check(!pl_ready_o, "R1 payload ready low", 64'(pl_ready_o), 64'd0);
        check(tx_status_o == 2'd0, "R1 status none", 64'(tx_status_o), 64'd0);
        ip_ready_i = 1'b0;

        send_pkt(32'hc0123478, 16'h8532, 16'h1467, 16'd3, 16'h0000, 3, 100, 0, 0);
        send_pkt(32'hc0123475, 16'h8532, 16'h1467, 16'd5, 16'hbeef, 5, 100, 0, 0);
        send_pkt(32'h0a000001, 16'h1234, 16'h5678, 16'd0, 16'h9abc, 0, 60, 0, 0);   // R7
        send_pkt(32'h0a000002, 16'hffff, 16'h0001, 16'hfffc, 16'h1111, 3, 70, 0, 0); // length wrap
        send_pkt(32'h0a000003, 16'h4000, 16'h0050, 16'd6, 16'h2222, 6, 50, 1, 0);    // R9
        send_pkt(32'h0a000004, 16'h0007, 16'h0008, 16'd4, 16'h3333, 4, 80, 0, 1);    // error
        for (int n = 0; n < 25; n++) begin
            int np;
            np = 1 + int'($urandom % 24);
            send_pkt($urandom, 16'($urandom), 16'($urandom), 16'(np), 16'($urandom),
                     np, 40 + int'($urandom % 61), ($urandom % 5) == 0, ($urandom % 4) == 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule